// File: doc/BRIEF.md
# Embedded Program/Erase Status Engine

This block runs the word-program and erase operations that a command decoder hands over, against a behavioural array of 16-bit words. Operation times are set in clock cycles, so the same logic can model real program and erase durations or run a shortened version in simulation. The block applies the sector map and the boot-region protection rules. While an operation runs, a read returns a status word instead of array data. Bit 7 of that word is a data-polling flag. Bit 6 flips on every read access.

When no operation is running, a read returns the stored word. If the identification mode input is high, a read returns the identification codes instead. The address is split into a 5-bit region index in the top bits and `BLK_W` bits of offset within the region. Region 0 is the boot region. Region 1 is parameter sector A and region 2 is parameter sector B. Regions 3 to 31 together form the main sector.

Top module: `flash_op_engine`

## Requirements
- R1: A completed program leaves the target word equal to its previous value AND the program data. Bits can only go from 1 to 0. Only an erase sets bits back to 1.
- R2: An operation is accepted when `op_valid` is high and `busy` is low. `op_code` is encoded as 01 = program, 10 = sector erase, 11 = chip erase, 00 = nothing. `busy` goes high in the cycle after acceptance. A program keeps `busy` high for exactly `PROG_CYC` cycles. Requests made while `busy` is high are ignored. After reset, `busy` and `rd_data` are 0.
- R3: A read during a program returns a status word. Bit 7 is the inverse of bit 7 of the program data. Bit 6 is 0 on the first read after acceptance and then alternates on each later read. All other bits are 0.
- R4: A read during an erase returns a status word. Bit 7 is 0 and bit 6 alternates in the same way as for a program. All other bits are 0.
- R5: A sector erase selects a sector by the region index of `op_addr`: 1 selects parameter sector A, 2 selects parameter sector B, 31 selects the main sector. Any other index drops the request and `busy` stays low. The erase sets the selected words to FFFF and leaves every other word unchanged.
- R6: When protection is not in force, a main-sector erase also erases the boot region. Protection is in force when `boot_lock` is 1 and `lock_ovr` is 0. When protection is in force, a main-sector erase leaves the boot region unchanged.
- R7: When protection is in force, a program aimed at the boot region is dropped, and so is a chip erase. In both cases `busy` stays low and the array is unchanged. With `lock_ovr` high, both operations run normally.
- R8: A chip erase sets every word to FFFF. Every erase keeps `busy` high for max(`ERASE_CYC`, 2^`ADDR_W`) cycles.
- R9: With `id_mode` high and no operation running, reads return fixed values: address 0 reads 001F, address 1 reads 0092, and address 2 reads `boot_lock` in bit 0. Every other address reads 0000.
- R10: A reset while a program is running ends the operation, lowers `busy`, and leaves the target word at 0000.
- R11: `rd_data` is loaded on a clock edge where `rd_en` is high, with one cycle of latency. It holds its value on every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation request |
| op_code | input | 2 | Operation kind (01 program, 10 sector erase, 11 chip erase) |
| op_addr | input | ADDR_W | Word address or sector address |
| op_data | input | 16 | Program data |
| boot_lock | input | 1 | Boot region protection state |
| lock_ovr | input | 1 | Protection override |
| id_mode | input | 1 | Identification read mode |
| rd_en | input | 1 | Read access strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 16 | Read result (array, identification or status) |
| busy | output | 1 | Operation in progress |

## Verification
The bench builds the block with `BLK_W` = 4, which gives 512 words and 16 words per region. It sets `PROG_CYC` = 20 and `ERASE_CYC` = 600. With these values, every sector can be erased and checked word by word within a short run. Because `ERASE_CYC` is larger than the array depth, the erase length is set by the timer rather than by the sweep. The small program time leaves room for many random program and read-back rounds, and for several status reads inside one busy window.

// File: rtl/fope_pkg.sv
// Shared types and constants for the program/erase status engine.
// Assumes a 5-bit region index in the top address bits.
package fope_pkg;
    localparam int REGION_W = 5;
    localparam int DATA_W   = 16;

    typedef enum logic [1:0] {
        OPC_NONE = 2'b00,
        OPC_PROG = 2'b01,
        OPC_SECT = 2'b10,
        OPC_CHIP = 2'b11
    } opc_t;

    // Region classes double as bit positions in the erase mask.
    typedef enum logic [1:0] {
        CLS_BOOT = 2'd0,
        CLS_PARA = 2'd1,
        CLS_PARB = 2'd2,
        CLS_MAIN = 2'd3
    } cls_t;

    localparam logic [DATA_W-1:0] ID_MAKER = 16'h001F;
    localparam logic [DATA_W-1:0] ID_PART  = 16'h0092;

    // Maps a region index to its sector class.
    function automatic cls_t region_class(input logic [REGION_W-1:0] r);
        case (r)
            5'd0:    return CLS_BOOT;
            5'd1:    return CLS_PARA;
            5'd2:    return CLS_PARB;
            default: return CLS_MAIN;
        endcase
    endfunction
endpackage

// File: rtl/fope_sector_map.sv
// Decides whether a request may start and which sector classes an erase covers.
// Purely combinational. Assumes the region index has already been extracted.
module fope_sector_map
    import fope_pkg::*;
(
    input  opc_t                opc,
    input  logic [REGION_W-1:0] region,
    input  logic                boot_lock,
    input  logic                lock_ovr,
    output logic                allow,
    output logic [3:0]          mask
);
    logic guard;

    // Protection is in force only when the lock is set and not overridden.
    always_comb guard = boot_lock & ~lock_ovr;

    // Request qualification and erase coverage.
    always_comb begin
        allow = 1'b0;
        mask  = 4'b0000;
        case (opc)
            OPC_PROG: allow = !((region == 5'd0) && guard);
            OPC_SECT: begin
                if (region == 5'd1) begin
                    allow = 1'b1;
                    mask  = 4'b0010;
                end else if (region == 5'd2) begin
                    allow = 1'b1;
                    mask  = 4'b0100;
                end else if (region == 5'd31) begin
                    allow = 1'b1;
                    mask  = guard ? 4'b1000 : 4'b1001;
                end
            end
            OPC_CHIP: begin
                allow = !guard;
                mask  = 4'b1111;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fope_timer.sv
// Down-counter for operation duration. It is loaded at operation start and
// reports last when it reaches zero. Assumes both durations are at least 1.
module fope_timer #(
    parameter int PROG_CYC  = 2500,
    parameter int ERASE_CYC = 500000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic is_erase,
    input  logic run,
    output logic last
);
    localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;

    // Load on start, count down while the operation runs.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= is_erase ? CW'(ERASE_CYC - 1) : CW'(PROG_CYC - 1);
        else if (run && (cnt != '0))
            cnt <= cnt - 1'b1;
    end

    // Expiry flag.
    always_comb last = (cnt == '0);
endmodule

// File: rtl/fope_array.sv
// Behavioural word array with an AND-write port for programming and a plain
// write port for erase and abort. Contents are not reset.
module fope_array #(
    parameter int ADDR_W = 11
) (
    input  logic                       clk,
    input  logic                       pgm_en,
    input  logic                       set_en,
    input  logic [ADDR_W-1:0]          waddr,
    input  logic [fope_pkg::DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0]          raddr,
    output logic [fope_pkg::DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [fope_pkg::DATA_W-1:0] mem [DEPTH];

    // Write port: a plain write takes priority over the AND-write.
    always_ff @(posedge clk) begin
        if (set_en)
            mem[waddr] <= wdata;
        else if (pgm_en)
            mem[waddr] <= mem[waddr] & wdata;
    end

    // Asynchronous read port.
    always_comb rdata = mem[raddr];
endmodule

// File: rtl/fope_read_path.sv
// Read result register. Selects the status word while busy, the
// identification codes in identification mode, or array data otherwise.
// Owns the flip bit, which is cleared when an operation starts.
module fope_read_path
    import fope_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_flip,
    input  logic              busy,
    input  logic              prog,
    input  logic              poll_bit,
    input  logic              id_mode,
    input  logic              boot_lock,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] arr_word,
    output logic [DATA_W-1:0] rd_data
);
    logic              flip;
    logic [DATA_W-1:0] nxt;

    // Flip bit: inverts on every read access during an operation.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_flip)
            flip <= 1'b0;
        else if (rd_en && busy)
            flip <= ~flip;
    end

    // Source selection for the next read result.
    always_comb begin
        nxt = '0;
        if (busy) begin
            nxt[7] = prog ? ~poll_bit : 1'b0;
            nxt[6] = flip;
        end else if (id_mode) begin
            if (rd_addr == ADDR_W'(0))
                nxt = ID_MAKER;
            else if (rd_addr == ADDR_W'(1))
                nxt = ID_PART;
            else if (rd_addr == ADDR_W'(2))
                nxt[0] = boot_lock;
        end else begin
            nxt = arr_word;
        end
    end

    // Result register: loads only on a read access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= nxt;
    end
endmodule

// File: rtl/flash_op_engine.sv
// Program/erase status engine. Accepts one operation at a time, times it,
// sweeps the array for erases, and applies the protection rules. Assumes the
// command decoder has already decoded the bus command sequences.
module flash_op_engine
    import fope_pkg::*;
#(
    parameter  int BLK_W     = 6,
    parameter  int PROG_CYC  = 2500,
    parameter  int ERASE_CYC = 500000000,
    localparam int ADDR_W    = BLK_W + REGION_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_code,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_data,
    input  logic              boot_lock,
    input  logic              lock_ovr,
    input  logic              id_mode,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy
);
    logic              allow, accept, done, tmr_last, sweep_end, abort;
    logic              cur_prog, sweep_done, sweep_wr;
    logic [3:0]        map_mask, mask;
    logic [ADDR_W-1:0] cur_addr, sweep_ptr, waddr;
    logic [DATA_W-1:0] cur_data, wdata, arr_word;
    logic              pgm_en, set_en;
    opc_t              opc;

    always_comb opc = opc_t'(op_code);

    fope_sector_map u_map (
        .opc       (opc),
        .region    (op_addr[ADDR_W-1:BLK_W]),
        .boot_lock (boot_lock),
        .lock_ovr  (lock_ovr),
        .allow     (allow),
        .mask      (map_mask)
    );

    fope_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .is_erase (opc != OPC_PROG),
        .run      (busy),
        .last     (tmr_last)
    );

    // Acceptance and completion conditions.
    always_comb begin
        accept    = op_valid && !busy && allow;
        sweep_end = sweep_done || (sweep_ptr == '1);
        done      = busy && tmr_last && (cur_prog || sweep_end);
    end

    // Operation state: capture on accept, sweep during erase, clear on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            cur_prog   <= 1'b0;
            cur_addr   <= '0;
            cur_data   <= '0;
            mask       <= '0;
            sweep_ptr  <= '0;
            sweep_done <= 1'b0;
        end else if (accept) begin
            busy       <= 1'b1;
            cur_prog   <= (opc == OPC_PROG);
            cur_addr   <= op_addr;
            cur_data   <= op_data;
            mask       <= map_mask;
            sweep_ptr  <= '0;
            sweep_done <= 1'b0;
        end else if (busy) begin
            if (done)
                busy <= 1'b0;
            if (!cur_prog && !sweep_done) begin
                sweep_ptr <= sweep_ptr + 1'b1;
                if (sweep_ptr == '1)
                    sweep_done <= 1'b1;
            end
        end
    end

    // Array write selection: abort clear, erase sweep, or program AND.
    always_comb begin
        abort    = !rst_n && busy && cur_prog;
        sweep_wr = rst_n && busy && !cur_prog && !sweep_done
                   && mask[region_class(sweep_ptr[ADDR_W-1:BLK_W])];
        set_en   = abort || sweep_wr;
        pgm_en   = rst_n && done && cur_prog;
        waddr    = cur_prog ? cur_addr : sweep_ptr;
        wdata    = abort ? '0 : (cur_prog ? cur_data : '1);
    end

    fope_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk    (clk),
        .pgm_en (pgm_en),
        .set_en (set_en),
        .waddr  (waddr),
        .wdata  (wdata),
        .raddr  (rd_addr),
        .rdata  (arr_word)
    );

    fope_read_path #(.ADDR_W(ADDR_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_flip  (accept),
        .busy      (busy),
        .prog      (cur_prog),
        .poll_bit  (cur_data[7]),
        .id_mode   (id_mode),
        .boot_lock (boot_lock),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .arr_word  (arr_word),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/fope_chk.sv
// Assertion checker for flash_op_engine, attached by bind.
module fope_chk #(
    parameter int BLK_W  = 6,
    parameter int ADDR_W = BLK_W + 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [1:0]        op_code,
    input logic [ADDR_W-1:0] op_addr,
    input logic              boot_lock,
    input logic              lock_ovr,
    input logic              busy,
    input logic              cur_prog,
    input logic              cur_bit7,
    input logic              rd_en,
    input logic [15:0]       rd_data
);
    // R2
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(op_valid));

    // R7
    boot_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy && op_code == 2'b01 && op_addr[ADDR_W-1:BLK_W] == 5'd0
         && boot_lock && !lock_ovr) |=> !busy);

    // R3
    prog_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy && cur_prog) |=> (rd_data[7] == !$past(cur_bit7)));

    // R4
    erase_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy && !cur_prog) |=> (rd_data[7] == 1'b0));

    // R4
    flip_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy && $past(rd_en && busy)) |=> (rd_data[6] != $past(rd_data[6])));

    // R11
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

bind flash_op_engine fope_chk #(.BLK_W(BLK_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .op_addr   (op_addr),
    .boot_lock (boot_lock),
    .lock_ovr  (lock_ovr),
    .busy      (busy),
    .cur_prog  (cur_prog),
    .cur_bit7  (cur_data[7]),
    .rd_en     (rd_en),
    .rd_data   (rd_data)
);

// File: tb/sim_flash_op_engine.sv
module sim_flash_op_engine;
    localparam int BLK_W  = 4;
    localparam int PCYC   = 20;
    localparam int ECYC   = 600;
    localparam int AW     = BLK_W + 5;
    localparam int DEPTH  = 1 << AW;
    localparam int ELEN   = (ECYC > DEPTH) ? ECYC : DEPTH;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [1:0]    op_code = 2'b00;
    logic [AW-1:0] op_addr = '0;
    logic [15:0]   op_data = '0;
    logic          boot_lock = 1'b0, lock_ovr = 1'b0, id_mode = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [15:0]   rd_data;
    logic          busy;

    logic [15:0] model [DEPTH];
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    flash_op_engine #(.BLK_W(BLK_W), .PROG_CYC(PCYC), .ERASE_CYC(ECYC)) u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_addr(op_addr), .op_data(op_data), .boot_lock(boot_lock),
        .lock_ovr(lock_ovr), .id_mode(id_mode), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy));

    function automatic logic [15:0] status_word(input logic prog, input logic d7, input logic fl);
        logic [15:0] s = '0;
        s[7] = prog ? ~d7 : 1'b0;
        s[6] = fl;
        return s;
    endfunction

    function automatic int region(input int a);
        return a >> BLK_W;
    endfunction

    function automatic logic [AW-1:0] in_region(input int r, input int off);
        return AW'((r << BLK_W) + (off % (1 << BLK_W)));
    endfunction

    // Erases model words: m[0]=boot, m[1]=sector A, m[2]=sector B, m[3]=main.
    task automatic model_erase(input logic [3:0] m);
        for (int a = 0; a < DEPTH; a++) begin
            int r = region(a);
            int c = (r == 0) ? 0 : (r == 1) ? 1 : (r == 2) ? 2 : 3;
            if (m[c]) model[a] = 16'hFFFF;
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] code, input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        op_valid = 1'b1; op_code = code; op_addr = a; op_data = d;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 100000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [15:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic prog_chk(input logic [AW-1:0] a, input logic [15:0] d, input string req);
        int n;
        logic [15:0] v;
        do_op(2'b01, a, d);
        wait_idle(n);
        model[a] = model[a] & d;
        rd(a, v);
        chk(req, v, model[a]);
    endtask

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_up();
    end

    initial begin
        int n;
        logic [15:0] v;
        logic [AW-1:0] a;
        void'($urandom(32'h5EED));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        chk("R2 reset busy", busy, 1'b0);
        chk("R2 reset rd_data", rd_data, 16'h0);

        // R8 chip erase, timer-bounded length
        do_op(2'b11, '0, '0);
        wait_idle(n);
        chk("R8 erase length", n, ELEN);
        model_erase(4'b1111);
        for (int i = 0; i < 8; i++) begin
            a = AW'($urandom_range(0, DEPTH - 1));
            rd(a, v);
            chk("R8 chip erase word", v, 16'hFFFF);
        end

        // R2 program length, R1 AND semantics
        do_op(2'b01, AW'(53), 16'hF0F0);
        wait_idle(n);
        chk("R2 program length", n, PCYC);
        model[53] = 16'hF0F0;
        rd(AW'(53), v);
        chk("R1 program", v, 16'hF0F0);
        prog_chk(AW'(53), 16'h0FFF, "R1 and-merge");
        prog_chk(AW'(53), 16'hFFFF, "R1 no set back");

        // R3 status during program, R2 request ignored while busy
        do_op(2'b01, AW'(70), 16'h0080);
        rd(AW'(0), v); chk("R3 first poll", v, status_word(1'b1, 1'b1, 1'b0));
        rd(AW'(5), v); chk("R3 second poll", v, status_word(1'b1, 1'b1, 1'b1));
        do_op(2'b01, AW'(71), 16'h0000);
        rd(AW'(9), v); chk("R3 third poll", v, status_word(1'b1, 1'b1, 1'b0));
        wait_idle(n);
        model[70] = 16'h0080;
        rd(AW'(70), v); chk("R3 true data after", v, 16'h0080);
        rd(AW'(71), v); chk("R2 ignored while busy", v, 16'hFFFF);

        // R1 random program rounds
        for (int i = 0; i < 40; i++) begin
            a = AW'($urandom_range(0, DEPTH - 1));
            prog_chk(a, 16'($urandom), "R1 random program");
            a = AW'($urandom_range(0, DEPTH - 1));
            rd(a, v);
            chk("R1 random readback", v, model[a]);
        end

        // R4 status during erase, R5 sector A erase only
        do_op(2'b10, in_region(1, 7), '0);
        rd(AW'(3), v); chk("R4 first poll", v, status_word(1'b0, 1'b0, 1'b0));
        rd(AW'(3), v); chk("R4 second poll", v, status_word(1'b0, 1'b0, 1'b1));
        wait_idle(n);
        model_erase(4'b0010);
        for (int r = 0; r < 32; r++) begin
            a = in_region(r, $urandom_range(0, 15));
            rd(a, v);
            chk("R5 sector A erase", v, model[a]);
        end
        do_op(2'b10, in_region(2, 0), '0);
        wait_idle(n);
        model_erase(4'b0100);
        for (int o = 0; o < 16; o++) begin
            rd(in_region(2, o), v);
            chk("R5 sector B erase", v, 16'hFFFF);
        end

        // R5 bad sector address dropped
        do_op(2'b10, in_region(5, 0), '0);
        chk("R5 bad sector busy", busy, 1'b0);

        // R6 unlocked main erase takes boot along
        prog_chk(in_region(0, 7), 16'h0000, "R1 boot program");
        prog_chk(in_region(20, 1), 16'h0000, "R1 main program");
        do_op(2'b10, in_region(31, 0), '0);
        wait_idle(n);
        model_erase(4'b1001);
        rd(in_region(0, 7), v); chk("R6 unlocked boot erased", v, 16'hFFFF);
        rd(in_region(20, 1), v); chk("R6 main erased", v, 16'hFFFF);

        // R7 protection in force
        prog_chk(in_region(0, 3), 16'h1234, "R1 boot program");
        prog_chk(in_region(10, 3), 16'h0000, "R1 main program");
        boot_lock = 1'b1;
        do_op(2'b01, in_region(0, 3), 16'h0000);
        chk("R7 locked program busy", busy, 1'b0);
        rd(in_region(0, 3), v); chk("R7 locked program word", v, 16'h1234);
        do_op(2'b11, '0, '0);
        chk("R7 locked chip erase busy", busy, 1'b0);
        rd(in_region(10, 3), v); chk("R7 chip erase dropped", v, 16'h0000);
        // R6 locked main erase keeps boot
        do_op(2'b10, in_region(31, 2), '0);
        wait_idle(n);
        model_erase(4'b1000);
        rd(in_region(0, 3), v); chk("R6 locked boot kept", v, 16'h1234);
        rd(in_region(10, 3), v); chk("R6 locked main erased", v, 16'hFFFF);

        // R9 identification reads
        id_mode = 1'b1;
        rd(AW'(0), v); chk("R9 maker code", v, 16'h001F);
        rd(AW'(1), v); chk("R9 part code", v, 16'h0092);
        rd(AW'(2), v); chk("R9 lock bit set", v, 16'h0001);
        rd(AW'(5), v); chk("R9 other address", v, 16'h0000);
        boot_lock = 1'b0;
        rd(AW'(2), v); chk("R9 lock bit clear", v, 16'h0000);
        boot_lock = 1'b1;
        id_mode = 1'b0;

        // R7 override lets boot changes through
        lock_ovr = 1'b1;
        prog_chk(in_region(0, 3), 16'h0F00, "R7 override program");
        do_op(2'b10, in_region(31, 0), '0);
        wait_idle(n);
        model_erase(4'b1001);
        rd(in_region(0, 3), v); chk("R6 override boot erased", v, 16'hFFFF);
        lock_ovr = 1'b0;
        boot_lock = 1'b0;

        // R10 reset during program
        do_op(2'b01, AW'(64), 16'hFFFF);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R10 busy after abort", busy, 1'b0);
        model[64] = 16'h0000;
        rd(AW'(64), v); chk("R10 corrupted word", v, 16'h0000);

        // R11 hold without read strobe
        rd(in_region(0, 3), v);
        rd_addr = AW'(64);
        repeat (3) @(negedge clk);
        chk("R11 hold", rd_data, 16'hFFFF);
        rd(AW'(64), v); chk("R11 load on strobe", v, 16'h0000);

        finish_up();
    end
endmodule